// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Counter

This block measures how fast a test clock runs. The host writes one control word that carries a window length in reference ticks and an enable flag. While the window is open, the block counts rising edges of the test clock. The reference clock is the crystal divided by four, at 4.8 MHz. When the window closes, the edge count is carried back into the reference domain as a whole, and a done flag is raised. The host turns the count into hertz, and it also handles any source selection or divider scaling ahead of the block.

The window opens and closes in the reference domain. It reaches the test domain through a two-flop synchroniser. The test-domain counter clears itself only on its own clock, when it sees the window open. When the window closes, that domain takes a snapshot of the counter and flips a toggle. In the reference domain, the synchronised toggle loads a shadow register, so the host never reads a torn count.

If the test clock is stopped, no toggle ever arrives. After a settle window, the block reports done with the shadow unchanged. Two measurements of different lengths then return the same stale count, and the host uses that to detect a dead clock.

Top module: `freq_meter`

## Requirements
- R1: After the active-low asynchronous reset, the status word reads all zero and the measurement window is closed.
- R2: The control word holds the tick count in bits TICK_W-1..0 and the enable flag at bit TICK_W (bit 20 by default). A write with enable set, made while idle with a nonzero count, opens a window that lasts exactly that many reference cycles.
- R3: The done flag sits at status bit CNT_W (bit 25 by default). It never rises before the programmed number of reference cycles has elapsed. Once it is set, the count field in bits CNT_W-1..0 equals the number of test-clock edges in the window, within ±2.
- R4: A write with enable clear stops the measurement, reloads the tick count and clears done on the next cycle. If it lands in the same cycle that the window would expire, the stop wins and done never rises.
- R5: The count field keeps its value across a stop write and while done is held. It changes only when a later measurement completes.
- R6: A write with enable set while done is set is ignored: done stays set and the count does not change.
- R7: A start with a tick count of zero sets done on the next cycle, with a count of zero.
- R8: If the test clock is stopped, done still rises SETTLE_CYC reference cycles after the window ends, and the count keeps its previous value whatever the window length.
- R9: The test-clock counter saturates at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference timebase and host-side clock |
| tst_clk | input | 1 | Clock under measurement |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | TICK_W+1 | Tick count in the low bits, enable at the top bit |
| status | output | CNT_W+1 | Done flag at the top bit, edge count below it |

## Verification
The window's natural expiry and a host stop write can fall in the same reference cycle. The bench provokes this by counting cycles from the start write and placing the stop so that it is sampled on exactly the edge where the tick timer reaches its last count. It then requires that done stays clear over a long wait afterwards, and that the count still shows the previous result, so the stop has won and the late snapshot has been discarded.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } fm_state_e;
endpackage

// File: rtl/fm_sync.sv
// Two-flop synchroniser with asynchronous active-low reset.
module fm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fm_tst_count.sv
// Test-clock domain: counts edges while the synchronised window is open,
// clears on window open, snapshots and toggles on window close.
module fm_tst_count #(
  parameter int CNT_W = 25
) (
  input  logic             tst_clk,
  input  logic             rst_n,
  input  logic             gate_async,
  output logic [CNT_W-1:0] snap,
  output logic             snap_tog
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             gate_s;
  logic             gate_d;
  logic [CNT_W-1:0] cnt;

  fm_sync #(.W(1)) u_gate_sync (
    .clk  (tst_clk),
    .rst_n(rst_n),
    .d    (gate_async),
    .q    (gate_s)
  );

  always_ff @(posedge tst_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d   <= 1'b0;
      cnt      <= '0;
      snap     <= '0;
      snap_tog <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (gate_s && !gate_d) begin
        cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (gate_s) begin
        cnt <= (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
      end
      if (!gate_s && gate_d) begin
        snap     <= cnt;
        snap_tog <= ~snap_tog;
      end
    end
  end
endmodule

// File: rtl/fm_ref_ctrl.sv
// Reference domain: control decode, tick timer, settle window, shadow count.
module fm_ref_ctrl
  import fm_pkg::*;
#(
  parameter int TICK_W     = 20,
  parameter int CNT_W      = 25,
  parameter int SETTLE_CYC = 64
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [TICK_W-1:0] ctl_ticks,
  input  logic              ctl_en,
  input  logic [CNT_W-1:0]  snap,
  input  logic              snap_tog,
  output logic              gate,
  output logic              idle,
  output logic              done,
  output logic [CNT_W-1:0]  count
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);
  localparam logic [TICK_W-1:0] TICK_ONE = TICK_W'(1);

  fm_state_e         state;
  logic [TICK_W-1:0] timer;
  logic [SET_W-1:0]  settle;
  logic              tog_s;
  logic              tog_d;
  logic              tog_evt;

  fm_sync #(.W(1)) u_tog_sync (
    .clk  (ref_clk),
    .rst_n(rst_n),
    .d    (snap_tog),
    .q    (tog_s)
  );

  assign tog_evt = tog_s ^ tog_d;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      timer  <= '0;
      settle <= '0;
      gate   <= 1'b0;
      count  <= '0;
      tog_d  <= 1'b0;
    end else begin
      tog_d <= tog_s;
      if (ctl_wr && !ctl_en) begin
        state <= ST_IDLE;
        gate  <= 1'b0;
        timer <= ctl_ticks;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (ctl_wr && ctl_en) begin
              if (ctl_ticks == '0) begin
                state <= ST_DONE;
                count <= '0;
              end else begin
                state <= ST_RUN;
                timer <= ctl_ticks;
                gate  <= 1'b1;
              end
            end
          end
          ST_RUN: begin
            if (timer == TICK_ONE) begin
              state  <= ST_SETTLE;
              gate   <= 1'b0;
              settle <= '0;
            end else begin
              timer <= timer - 1'b1;
            end
          end
          ST_SETTLE: begin
            if (tog_evt) begin
              count <= snap;
              state <= ST_DONE;
            end else if (settle == SET_LAST) begin
              state <= ST_DONE;
            end else begin
              settle <= settle + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign done = (state == ST_DONE);
  assign idle = (state == ST_IDLE);
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int TICK_W     = 20,
  parameter int CNT_W      = 25,
  parameter int SETTLE_CYC = 64
) (
  input  logic              ref_clk,
  input  logic              tst_clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [TICK_W:0]   ctl_word,
  output logic [CNT_W:0]    status
);
  logic             ref_gate;
  logic             ref_idle;
  logic             ref_done;
  logic [CNT_W-1:0] ref_count;
  logic [CNT_W-1:0] tst_snap;
  logic             tst_tog;

  fm_ref_ctrl #(
    .TICK_W    (TICK_W),
    .CNT_W     (CNT_W),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ref (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_ticks(ctl_word[TICK_W-1:0]),
    .ctl_en   (ctl_word[TICK_W]),
    .snap     (tst_snap),
    .snap_tog (tst_tog),
    .gate     (ref_gate),
    .idle     (ref_idle),
    .done     (ref_done),
    .count    (ref_count)
  );

  fm_tst_count #(.CNT_W(CNT_W)) u_tst (
    .tst_clk   (tst_clk),
    .rst_n     (rst_n),
    .gate_async(ref_gate),
    .snap      (tst_snap),
    .snap_tog  (tst_tog)
  );

  assign status = {ref_done, ref_count};
endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk #(
  parameter int TICK_W = 20,
  parameter int CNT_W  = 25
) (
  input logic            ref_clk,
  input logic            rst_n,
  input logic            ctl_wr,
  input logic [TICK_W:0] ctl_word,
  input logic [CNT_W:0]  status,
  input logic            gate,
  input logic            idle
);
  // R2: the window opens only in answer to a start write
  a_r2_gate_from_start: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(gate) |-> $past(ctl_wr && ctl_word[TICK_W]));

  // R3: done is never reported while the window is open
  a_r3_done_window_closed: assert property (@(posedge ref_clk) disable iff (!rst_n)
    status[CNT_W] |-> !gate);

  // R4: a stop write clears done on the next cycle
  a_r4_stop_clears_done: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ctl_wr && !ctl_word[TICK_W]) |=> !status[CNT_W]);

  // R5: with no write, a set done and its count hold still
  a_r5_hold_while_done: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (status[CNT_W] && !ctl_wr) |=> $stable(status));

  // R6: a start while done is set changes nothing
  a_r6_start_ignored: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (status[CNT_W] && ctl_wr && ctl_word[TICK_W]) |=> $stable(status));

  // R7: zero ticks completes at once with a zero count
  a_r7_zero_ticks: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (idle && ctl_wr && ctl_word[TICK_W] && ctl_word[TICK_W-1:0] == '0)
    |=> (status == {1'b1, {CNT_W{1'b0}}}));
endmodule

bind freq_meter freq_meter_chk #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_chk (
  .ref_clk (ref_clk),
  .rst_n   (rst_n),
  .ctl_wr  (ctl_wr),
  .ctl_word(ctl_word),
  .status  (status),
  .gate    (ref_gate),
  .idle    (ref_idle)
);

// File: tb/freq_meter_bench.sv
`timescale 1ns/1ps
module freq_meter_bench;
  localparam int TW = 20;
  localparam int CW = 25;
  localparam int STW = 12;
  localparam int SCW = 8;
  localparam int NV = 4;
  // each row: tick count, test half period in ps
  localparam int unsigned VEC [NV][2] = '{
    '{200, 1000}, '{300, 3000}, '{1000, 2000}, '{64, 5000}};

  logic ref_clk = 1'b0;
  logic tst_clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [TW:0] ctl_word = '0;
  logic [CW:0] status;
  logic s_wr = 1'b0;
  logic [STW:0] s_word = '0;
  logic [SCW:0] s_status;
  logic tst_run = 1'b1;
  realtime tst_half = 1.0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  freq_meter #(.TICK_W(TW), .CNT_W(CW)) u_freq_meter (
    .ref_clk(ref_clk), .tst_clk(tst_clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_word(ctl_word), .status(status));

  freq_meter #(.TICK_W(STW), .CNT_W(SCW)) u_freq_meter_sat (
    .ref_clk(ref_clk), .tst_clk(tst_clk), .rst_n(rst_n),
    .ctl_wr(s_wr), .ctl_word(s_word), .status(s_status));

  always #2 ref_clk = ~ref_clk;
  initial forever begin
    #(tst_half);
    if (tst_run) tst_clk = ~tst_clk;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; the write is sampled on the next posedge
  task automatic wr(input logic en, input int unsigned ticks);
    ctl_wr = 1'b1;
    ctl_word = {en, TW'(ticks)};
    @(negedge ref_clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_done(input int maxc, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      if (status[CW]) begin ok = 1'b1; break; end
      @(negedge ref_clk);
    end
  endtask

  int last_cnt;

  initial begin
    bit ok;
    int exp;
    int act;
    repeat (3) @(negedge ref_clk);
    chk(status == '0, "R1 reset status", status, 0);
    chk(s_status == '0, "R1 reset status small", s_status, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge ref_clk);

    // table-driven measurements
    for (int v = 0; v < NV; v++) begin
      tst_half = VEC[v][1] / 1000.0;
      wr(1'b0, VEC[v][0]);
      repeat (20) @(negedge ref_clk);
      wr(1'b1, VEC[v][0]);
      repeat (VEC[v][0]) @(negedge ref_clk);
      chk(!status[CW], "R3 done not before window end", status[CW], 0);
      wait_done(200, ok);
      chk(ok, "R2 measurement completes", ok, 1);
      exp = int'((VEC[v][0] * 4000) / (2 * VEC[v][1]));
      act = int'(status[CW-1:0]);
      chk(act >= exp - 2 && act <= exp + 2, "R3 edge count", act, exp);
      last_cnt = act;
    end

    // R6: start while done is set is ignored
    wr(1'b1, 50);
    chk(status == {1'b1, CW'(last_cnt)}, "R6 start ignored while done", status, {1'b1, CW'(last_cnt)});
    repeat (100) @(negedge ref_clk);
    chk(status == {1'b1, CW'(last_cnt)}, "R6 no new measurement", status, {1'b1, CW'(last_cnt)});

    // R4/R5: stop clears done, keeps count
    wr(1'b0, 50);
    chk(status == {1'b0, CW'(last_cnt)}, "R4 R5 stop clears done keeps count", status, {1'b0, CW'(last_cnt)});

    // R7: zero tick load
    wr(1'b1, 0);
    chk(status == {1'b1, CW'(0)}, "R7 zero ticks", status, {1'b1, CW'(0)});
    wr(1'b0, 0);

    // R4 collision: stop sampled on the edge the window expires
    tst_half = 1.0;
    wr(1'b1, 100);
    wait_done(300, ok);
    last_cnt = int'(status[CW-1:0]);
    wr(1'b0, 100);
    wr(1'b1, 100);
    repeat (99) @(negedge ref_clk);
    wr(1'b0, 100);
    repeat (200) @(negedge ref_clk);
    chk(!status[CW], "R4 stop wins over expiry", status[CW], 0);
    chk(int'(status[CW-1:0]) == last_cnt, "R5 count kept after abort", status[CW-1:0], last_cnt);

    // R8: stopped test clock gives a stale count
    tst_half = 3.0;
    wr(1'b1, 300);
    wait_done(400, ok);
    last_cnt = int'(status[CW-1:0]);
    chk(last_cnt >= 198 && last_cnt <= 202, "R3 count before stop", last_cnt, 200);
    wr(1'b0, 100);
    tst_run = 1'b0;
    repeat (10) @(negedge ref_clk);
    wr(1'b1, 100);
    repeat (100 + 60) @(negedge ref_clk);
    chk(!status[CW], "R8 done waits for settle window", status[CW], 0);
    wait_done(30, ok);
    chk(ok, "R8 done with stopped clock", ok, 1);
    chk(int'(status[CW-1:0]) == last_cnt, "R8 stale count short", status[CW-1:0], last_cnt);
    wr(1'b0, 250);
    wr(1'b1, 250);
    wait_done(400, ok);
    chk(ok && int'(status[CW-1:0]) == last_cnt, "R8 stale count long", status[CW-1:0], last_cnt);
    wr(1'b0, 0);
    tst_run = 1'b1;
    tst_half = 1.0;
    repeat (20) @(negedge ref_clk);

    // R9: saturation on the narrow instance (done at bit 8)
    s_wr = 1'b1; s_word = {1'b0, STW'(400)};
    @(negedge ref_clk);
    s_word = {1'b1, STW'(400)};
    @(negedge ref_clk);
    s_wr = 1'b0;
    repeat (400 + 100) @(negedge ref_clk);
    chk(s_status == {1'b1, 8'hFF}, "R9 count saturates", s_status, {1'b1, 8'hFF});

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule